// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block paces a multiplexed 16-bit bus. It watches the address strobe and the data strobe of each bus cycle and drives two ready signals back to the bus master. The address-ready output holds off the address phase for a short programmable count. The data-ready output holds off the data phase for a count chosen by where the cycle points.

The address and the memory/I/O qualifier are captured while the address strobe is high. When that strobe falls, a 4-bit wait field is picked and loaded into a down-counter. For memory cycles the field comes from the top two address bits, one field per quadrant. For I/O cycles it comes from a second register that has its own four fields. An external not-ready input can mask data-ready at any time. A page-cache-miss flag can add one extra address-phase wait.

Software programs three registers through a plain write port: the memory wait register, the I/O wait register and a control register.

Top module: `bus_wait_gen`

## Requirements
- R1: For a memory cycle, data-ready stays low for exactly N data-strobe clocks and then goes high. N is the 4-bit field at bits [4q+3:4q] of the memory wait register, and q is address bits [15:14] latched at the end of the address strobe. N = 0 gives ready on the first data clock.
- R2: For an I/O cycle to a timed address, N is taken the same way from the I/O wait register.
- R3: After reset, both wait registers hold FFFF (15 waits everywhere), the address wait count is 3, and the miss-wait and full-I/O bits are clear. Both ready outputs are low.
- R4: Address-ready is low for the first A clocks of the address strobe and high from clock A+1 onward. A is control bits [1:0].
- R5: When control bit 2 is set and the miss input is high during the address strobe, the address hold lasts A+1 clocks. When bit 2 is clear, the miss input has no effect.
- R6: While the external not-ready input is high, data-ready is low. The wait counter keeps running underneath, so removing the override after the count has expired gives ready at once.
- R7: An I/O address is timed only if address bits [13:8] are zero, or if control bit 3 is set. An untimed I/O cycle gets zero data waits.
- R8: Data-ready is high only while the data strobe is high. Address-ready is high only while the address strobe is high.
- R9: Back-to-back cycles with no idle clock between them each load their own wait count.
- R10: A write with select 0 loads the memory wait register, select 1 loads the I/O wait register, and select 2 loads the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strobe | input | 1 | Address phase strobe, active high |
| data_strobe | input | 1 | Data phase strobe, active high |
| bus_ad | input | 16 | Multiplexed address/data bus |
| cyc_is_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| page_miss | input | 1 | Page-cache miss flag for the current cycle |
| ext_hold | input | 1 | External override, forces data-ready low |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 2 | Register select (0 memory, 1 I/O, 2 control) |
| cfg_wdata | input | 16 | Register write data |
| addr_rdy | output | 1 | Address-phase ready |
| data_rdy | output | 1 | Data-phase ready |

## Verification
The bench builds the block with its defaults: a 16-bit bus, four sections, 4-bit wait fields, a 2-bit address count and an 8-bit low span for timed I/O. With these values every field value from 0 to 15 can be reached, and the full address hold of 3 plus the miss wait gives four clocks. A behavioural model in the bench predicts both ready outputs on every clock. It runs every quadrant with several register patterns for memory and I/O, I/O accesses inside and outside the timed span with the extend bit set and clear, an override in the middle of the count and after it, and back-to-back cycles with no idle clock.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
    typedef enum logic [1:0] {
        CFG_MEM  = 2'd0,
        CFG_IO   = 2'd1,
        CFG_CTRL = 2'd2,
        CFG_NONE = 2'd3
    } cfg_sel_e;

    localparam int CTRL_MISS_BIT = 2;
    localparam int CTRL_IOX_BIT  = 3;
endpackage

// File: rtl/bwg_regs.sv
module bwg_regs
    import bwg_pkg::*;
#(
    parameter int SECT_N  = 4,
    parameter int FIELD_W = 4,
    parameter int AWAIT_W = 2,
    localparam int REG_W  = SECT_N * FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [1:0]         sel,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   mem_o,
    output logic [REG_W-1:0]   io_o,
    output logic [AWAIT_W-1:0] await_o,
    output logic               miss_en_o,
    output logic               io_ext_o
);
    typedef struct packed {
        logic [REG_W-1:0]   mem;
        logic [REG_W-1:0]   io;
        logic [AWAIT_W-1:0] aw;
        logic               miss_en;
        logic               io_ext;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            unique case (cfg_sel_e'(sel))
                CFG_MEM:  r_d.mem = wdata;
                CFG_IO:   r_d.io  = wdata;
                CFG_CTRL: begin
                    r_d.aw      = wdata[AWAIT_W-1:0];
                    r_d.miss_en = wdata[CTRL_MISS_BIT];
                    r_d.io_ext  = wdata[CTRL_IOX_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.mem     <= '1;
            r_q.io      <= '1;
            r_q.aw      <= '1;
            r_q.miss_en <= 1'b0;
            r_q.io_ext  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_o     = r_q.mem;
    assign io_o      = r_q.io;
    assign await_o   = r_q.aw;
    assign miss_en_o = r_q.miss_en;
    assign io_ext_o  = r_q.io_ext;

    p_write_mem_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == 2'd0) |=> (mem_o == $past(wdata)));
    p_write_io_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == 2'd1) |=> (io_o == $past(wdata)));
endmodule

// File: rtl/bwg_addr_phase.sv
module bwg_addr_phase #(
    parameter int AWAIT_W = 2,
    localparam int NEED_W = AWAIT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_strobe,
    input  logic               miss_i,
    input  logic               miss_en_i,
    input  logic [AWAIT_W-1:0] await_i,
    output logic               addr_rdy,
    output logic               fall_o
);
    typedef struct packed {
        logic              as_prev;
        logic [NEED_W-1:0] elapsed;
    } ast_t;

    ast_t s_d, s_q;
    logic [NEED_W-1:0] need;
    logic [NEED_W-1:0] elapsed_eff;

    always_comb begin
        need        = {1'b0, await_i} + NEED_W'(miss_en_i & miss_i);
        elapsed_eff = s_q.as_prev ? s_q.elapsed : '0;
        addr_rdy    = addr_strobe && (elapsed_eff >= need);
        fall_o      = s_q.as_prev && !addr_strobe;
        s_d.as_prev = addr_strobe;
        if (!addr_strobe)
            s_d.elapsed = '0;
        else if (elapsed_eff != '1)
            s_d.elapsed = elapsed_eff + 1'b1;
        else
            s_d.elapsed = elapsed_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_ardy_in_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_rdy |-> addr_strobe);
    p_ardy_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe && addr_rdy) |=> (!addr_strobe || !$stable(need) || addr_rdy));
    p_first_clock_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe && !s_q.as_prev && need != '0) |-> !addr_rdy);
endmodule

// File: rtl/bwg_sel.sv
module bwg_sel #(
    parameter int ADDR_W   = 16,
    parameter int SECT_N   = 4,
    parameter int FIELD_W  = 4,
    parameter int IO_LOW_W = 8,
    localparam int SECT_W  = $clog2(SECT_N),
    localparam int REG_W   = SECT_N * FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_strobe,
    input  logic [ADDR_W-1:0]  bus_ad,
    input  logic               is_mem,
    input  logic [REG_W-1:0]   mem_i,
    input  logic [REG_W-1:0]   io_i,
    input  logic               io_ext_i,
    output logic [FIELD_W-1:0] wait_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              mem;
    } lat_t;

    lat_t l_d, l_q;
    logic [FIELD_W-1:0] mem_f [SECT_N];
    logic [FIELD_W-1:0] io_f  [SECT_N];
    logic [SECT_W-1:0]  sect;
    logic               io_timed;

    for (genvar g = 0; g < SECT_N; g++) begin : g_unpack
        assign mem_f[g] = mem_i[g*FIELD_W +: FIELD_W];
        assign io_f[g]  = io_i[g*FIELD_W +: FIELD_W];
    end

    always_comb begin
        l_d = l_q;
        if (addr_strobe) begin
            l_d.addr = bus_ad;
            l_d.mem  = is_mem;
        end
        sect     = l_q.addr[ADDR_W-1 -: SECT_W];
        io_timed = io_ext_i || (l_q.addr[ADDR_W-SECT_W-1:IO_LOW_W] == '0);
        if (l_q.mem)
            wait_o = mem_f[sect];
        else if (io_timed)
            wait_o = io_f[sect];
        else
            wait_o = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    p_untimed_io_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_q.mem && !io_ext_i && l_q.addr[ADDR_W-SECT_W-1:IO_LOW_W] != '0) |-> (wait_o == '0));
endmodule

// File: rtl/bwg_data_phase.sv
module bwg_data_phase #(
    parameter int FIELD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FIELD_W-1:0] wait_i,
    input  logic               data_strobe,
    input  logic               ext_hold,
    output logic               data_rdy
);
    typedef struct packed {
        logic [FIELD_W-1:0] cnt;
    } dst_t;

    dst_t s_d, s_q;
    logic [FIELD_W-1:0] cnt_eff;

    always_comb begin
        cnt_eff  = load_i ? wait_i : s_q.cnt;
        data_rdy = data_strobe && (cnt_eff == '0) && !ext_hold;
        s_d.cnt  = (data_strobe && cnt_eff != '0) ? cnt_eff - 1'b1 : cnt_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_override_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_hold |-> !data_rdy);
    p_drdy_in_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        data_rdy |-> data_strobe);
    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (data_strobe && !load_i && s_q.cnt != '0) |=> (s_q.cnt == FIELD_W'($past(s_q.cnt) - 1'b1)));
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen #(
    parameter int ADDR_W   = 16,
    parameter int SECT_N   = 4,
    parameter int FIELD_W  = 4,
    parameter int AWAIT_W  = 2,
    parameter int IO_LOW_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      addr_strobe,
    input  logic                      data_strobe,
    input  logic [ADDR_W-1:0]         bus_ad,
    input  logic                      cyc_is_mem,
    input  logic                      page_miss,
    input  logic                      ext_hold,
    input  logic                      cfg_we,
    input  logic [1:0]                cfg_sel,
    input  logic [SECT_N*FIELD_W-1:0] cfg_wdata,
    output logic                      addr_rdy,
    output logic                      data_rdy
);
    localparam int REG_W = SECT_N * FIELD_W;

    logic [REG_W-1:0]   mem_reg, io_reg;
    logic [AWAIT_W-1:0] await_cnt;
    logic               miss_en, io_ext, as_fall;
    logic [FIELD_W-1:0] wait_n;

    bwg_regs #(.SECT_N(SECT_N), .FIELD_W(FIELD_W), .AWAIT_W(AWAIT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .mem_o(mem_reg), .io_o(io_reg), .await_o(await_cnt),
        .miss_en_o(miss_en), .io_ext_o(io_ext)
    );

    bwg_addr_phase #(.AWAIT_W(AWAIT_W)) u_aph (
        .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .miss_i(page_miss),
        .miss_en_i(miss_en), .await_i(await_cnt), .addr_rdy(addr_rdy), .fall_o(as_fall)
    );

    bwg_sel #(.ADDR_W(ADDR_W), .SECT_N(SECT_N), .FIELD_W(FIELD_W), .IO_LOW_W(IO_LOW_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .bus_ad(bus_ad),
        .is_mem(cyc_is_mem), .mem_i(mem_reg), .io_i(io_reg), .io_ext_i(io_ext),
        .wait_o(wait_n)
    );

    bwg_data_phase #(.FIELD_W(FIELD_W)) u_dph (
        .clk(clk), .rst_n(rst_n), .load_i(as_fall), .wait_i(wait_n),
        .data_strobe(data_strobe), .ext_hold(ext_hold), .data_rdy(data_rdy)
    );
endmodule

// File: tb/bus_wait_gen_bench.sv
module bus_wait_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_strobe = 1'b0, data_strobe = 1'b0;
    logic [15:0] bus_ad = '0;
    logic        cyc_is_mem = 1'b1, page_miss = 1'b0, ext_hold = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        addr_rdy, data_rdy;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    logic [15:0] sh_mem = 16'hFFFF, sh_io = 16'hFFFF;
    int sh_aw = 3;
    bit sh_miss = 0, sh_iox = 0;

    always #5 clk = ~clk;

    bus_wait_gen u_bus_wait_gen (
        .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .data_strobe(data_strobe),
        .bus_ad(bus_ad), .cyc_is_mem(cyc_is_mem), .page_miss(page_miss), .ext_hold(ext_hold),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .addr_rdy(addr_rdy), .data_rdy(data_rdy)
    );

    task automatic check(string tag, string what, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int exp_wait(logic [15:0] a, bit mem);
        int q = int'(a[15:14]);
        if (mem) return int'((sh_mem >> (4*q)) & 16'hF);
        if (!sh_iox && a[13:8] != 6'd0) return 0;
        return int'((sh_io >> (4*q)) & 16'hF);
    endfunction

    task automatic cfg_write(int sel, logic [15:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            0: sh_mem = val;
            1: sh_io = val;
            2: begin sh_aw = int'(val[1:0]); sh_miss = val[2]; sh_iox = val[3]; end
            default: ;
        endcase
    endtask

    // One bus cycle. ext_from/ext_len give the override window in data clocks.
    task automatic bus_cycle(string tag, logic [15:0] a, bit mem, bit miss,
                             int ext_from, int ext_len, int gap);
        int need = sh_aw + ((sh_miss && miss) ? 1 : 0);
        int n = exp_wait(a, mem);
        int a_len = need + 2;
        int d_len = n + 3 + ext_len;
        for (int i = 0; i < a_len; i++) begin
            @(negedge clk);
            addr_strobe = 1'b1; data_strobe = 1'b0;
            bus_ad = a; cyc_is_mem = mem; page_miss = miss; ext_hold = 1'b0;
            #1;
            check(tag, "addr_rdy", addr_rdy, i >= need);
            check("R8", "data_rdy in address phase", data_rdy, 1'b0);
        end
        for (int j = 0; j < d_len; j++) begin
            bit h = (j >= ext_from) && (j < ext_from + ext_len);
            @(negedge clk);
            addr_strobe = 1'b0; data_strobe = 1'b1; page_miss = 1'b0;
            bus_ad = ~a; ext_hold = h;
            #1;
            check(tag, "data_rdy", data_rdy, (j >= n) && !h);
            check("R8", "addr_rdy in data phase", addr_rdy, 1'b0);
        end
        for (int k = 0; k < gap; k++) begin
            @(negedge clk);
            data_strobe = 1'b0; ext_hold = 1'b0;
            #1;
            check("R8", "data_rdy idle", data_rdy, 1'b0);
            check("R8", "addr_rdy idle", addr_rdy, 1'b0);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] pats[3];
        pats[0] = 16'h3210; pats[1] = 16'h05A1; pats[2] = 16'hF00C;
        repeat (3) @(negedge clk);
        #1;
        check("R3", "addr_rdy in reset", addr_rdy, 1'b0);
        check("R3", "data_rdy in reset", data_rdy, 1'b0);
        rst_n = 1'b1;
        // R3: reset values give 15 data waits and 3 address waits
        bus_cycle("R3", 16'h1234, 1, 0, 99, 0, 1);
        bus_cycle("R3", 16'h8003, 0, 0, 99, 0, 1);
        // R1: every memory quadrant, several patterns
        foreach (pats[p]) begin
            cfg_write(0, pats[p]);
            for (int q = 0; q < 4; q++)
                bus_cycle("R1", {2'(q), 14'h0155}, 1, 0, 99, 0, 1);
        end
        // R10 / R4: address wait values
        for (int aw = 0; aw < 4; aw++) begin
            cfg_write(2, 16'(aw));
            bus_cycle("R4", 16'h4010, 1, 0, 99, 0, 1);
        end
        // R5: miss ignored when disabled, one extra wait when enabled
        cfg_write(2, 16'h0001);
        bus_cycle("R5", 16'hC000, 1, 1, 99, 0, 1);
        cfg_write(2, 16'h0005);
        bus_cycle("R5", 16'hC000, 1, 1, 99, 0, 1);
        bus_cycle("R5", 16'hC000, 1, 0, 99, 0, 1);
        cfg_write(2, 16'h0007);
        bus_cycle("R5", 16'h0000, 1, 1, 99, 0, 1);
        // R2 / R7: I/O sections, timed and untimed, extend clear and set
        cfg_write(2, 16'h0000);
        cfg_write(1, 16'h7352);
        for (int q = 0; q < 4; q++) begin
            bus_cycle("R2", {2'(q), 6'h00, 8'h42}, 0, 0, 99, 0, 1);
            bus_cycle("R7", {2'(q), 6'h11, 8'h42}, 0, 0, 99, 0, 1);
        end
        cfg_write(2, 16'h0008);
        for (int q = 0; q < 4; q++)
            bus_cycle("R7", {2'(q), 6'h2A, 8'h00}, 0, 0, 99, 0, 1);
        cfg_write(1, 16'h0B0E);
        for (int q = 0; q < 4; q++)
            bus_cycle("R2", {2'(q), 6'h00, 8'hFF}, 0, 0, 99, 0, 1);
        // R6: override mid-count, after count, and across the expiry
        cfg_write(0, 16'h6666);
        bus_cycle("R6", 16'h2000, 1, 0, 2, 2, 1);
        bus_cycle("R6", 16'h2000, 1, 0, 7, 3, 1);
        bus_cycle("R6", 16'h2000, 1, 0, 4, 5, 1);
        cfg_write(0, 16'h0000);
        bus_cycle("R6", 16'h2000, 1, 0, 0, 2, 1);
        // R9: back-to-back cycles with differing counts
        cfg_write(0, 16'h1F40);
        cfg_write(2, 16'h0002);
        bus_cycle("R9", 16'h0000, 1, 0, 99, 0, 0);
        bus_cycle("R9", 16'h4000, 1, 0, 99, 0, 0);
        bus_cycle("R9", 16'h8000, 1, 0, 99, 0, 0);
        bus_cycle("R9", 16'hC000, 1, 0, 99, 0, 0);
        bus_cycle("R9", 16'h0400, 0, 0, 99, 0, 1);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule